// File: doc/BRIEF.md
# Write-only I2C command-word receiver

This block is a receive-only I2C target for the control port of a single-channel converter. It samples the bus clock and data lines with the system clock and finds START and STOP conditions. It compares the first byte of each frame against a local 7-bit address and a hardwired broadcast address. When the header matches and asks for a write, the block gathers a fixed three-byte payload. It drives an open-drain acknowledge through a pull-down enable, and after the third byte it presents a 24-bit command word with a single-cycle valid strobe.

The block never returns data to the bus. A read request is left without an acknowledge, and the rest of that frame is ignored. Any byte after the third one in a frame is refused, and it does not change the word. A frame that ends early, or that a new START cuts off, leaves the last delivered word as it was. The bus must run at no more than one eighth of the system clock rate, because each line passes through a two-flop synchronizer before its edges are detected.

Top module: `i2c_word_sink`

## Requirements
- R1: A START (SDA falling while SCL is high) at any point, including in the middle of an address or data byte, aborts the current frame and restarts address reception. A STOP (SDA rising while SCL is high) ends the frame.
- R2: Bits are taken on rising SCL edges, most significant bit first, and every byte is followed by a ninth clock that carries the acknowledge.
- R3: The header byte is acknowledged only when its last bit (R/W) is 0 and its upper seven bits equal `local_addr_i` or the broadcast address 7'b1110011. Any other header receives no acknowledge and no data byte of that frame is acknowledged.
- R4: A header with R/W = 1 is not acknowledged, even with a matching address. The block then acknowledges nothing and produces no word until the next START or STOP.
- R5: After an accepted header, each of the first three data bytes is acknowledged, with the pull-down held for the whole high period of its ninth clock.
- R6: When the third data byte is complete, `word_o` holds {byte1, byte2, byte3} with the first byte in bits 23:16, and `word_vld_o` is high for exactly one system clock cycle.
- R7: A fourth or later data byte in the same frame is not acknowledged and produces neither a strobe nor a change of `word_o`.
- R8: `sda_pull_o` rises only after the SCL falling edge that ends the eighth bit of a byte and falls after the SCL falling edge that ends the ninth bit (or at a START or STOP). It is never high during bits one to eight.
- R9: A frame that ends, by STOP or by a new START, with fewer than three data bytes gives no strobe and leaves `word_o` unchanged.
- R10: After reset `sda_pull_o`, `word_vld_o` and `word_o` are all 0.
- R11: `word_o` changes only in a cycle in which `word_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| local_addr_i | input | 7 | Local 7-bit target address |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| word_o | output | 8*PAYLOAD_BYTES (24) | Last complete command word, first byte in the top bits |
| word_vld_o | output | 1 | One-cycle strobe when a new word is delivered |

## Verification
The hardest situations to reach from the ports are the frames that end in the wrong place. These are a START that lands in the middle of a header byte or after only one data byte, and a fourth byte that follows a valid three-byte payload. The bench drives its own bit-level bus master, which can stop a byte after any number of bits and issue a repeated START or a STOP there. Each truncated frame is followed by a clean frame with a different payload. This shows that no leftover partial bytes reach the delivered word and that the strobe count rises by exactly one. A sweep over all 128 header addresses checks the address compare. The same sweep confirms that the pull-down never appears during the eight data bits.

// File: rtl/i2c_ws_pkg.sv
package i2c_ws_pkg;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    FR_IDLE   = 2'd0,
    FR_SHIFT  = 2'd1,
    FR_ACK    = 2'd2,
    FR_IGNORE = 2'd3
  } fr_state_t;

  // Header byte is {address[6:0], rw}; accept writes to local or broadcast.
  function automatic logic header_accept(input logic [BYTE_W-1:0] hdr,
                                         input logic [ADDR_W-1:0] local_a,
                                         input logic [ADDR_W-1:0] bcast_a);
    logic [ADDR_W-1:0] a;
    a = hdr[BYTE_W-1:1];
    return (hdr[0] == 1'b0) && ((a == local_a) || (a == bcast_a));
  endfunction

  // Append one byte at the low end of an accumulating word.
  function automatic logic [63:0] append_byte(input logic [63:0] acc,
                                              input logic [BYTE_W-1:0] b);
    return (acc << BYTE_W) | {56'd0, b};
  endfunction

endpackage

// File: rtl/ws_line_sync.sv
module ws_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
  assign fall_o  = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/ws_bus_cond.sv
module ws_bus_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_ev,
  output logic stop_ev
);

  // Data may only move while the clock is low; a move with the clock high
  // is a frame delimiter.
  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;

endmodule

// File: rtl/ws_frame_ctl.sv
module ws_frame_ctl
  import i2c_ws_pkg::*;
#(
  parameter int unsigned   PAYLOAD_BYTES = 3,
  parameter logic [6:0]    BCAST_ADDR    = 7'b1110011,
  localparam int unsigned  WORD_W        = PAYLOAD_BYTES * BYTE_W,
  localparam int unsigned  CNT_W         = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADDR_W-1:0] local_addr,
  output logic              pull_o,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o,
  output logic [3:0]        bits_o
);

  localparam logic [3:0]       LAST_BIT  = 4'd8;
  localparam logic [CNT_W-1:0] BYTE_LIM  = CNT_W'(PAYLOAD_BYTES);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(PAYLOAD_BYTES - 1);

  fr_state_t          state_q;
  logic [3:0]         bit_cnt_q;
  logic [BYTE_W-1:0]  shreg_q;
  logic               in_hdr_q;
  logic [CNT_W-1:0]   byte_cnt_q;
  logic [WORD_W-1:0]  asm_q;
  logic [WORD_W-1:0]  word_q;
  logic               pull_q;
  logic               vld_q;

  logic [WORD_W-1:0]  asm_next;
  logic               byte_done;

  assign asm_next  = WORD_W'(append_byte(64'(asm_q), shreg_q));
  assign byte_done = scl_fall && (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FR_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      in_hdr_q   <= 1'b0;
      byte_cnt_q <= '0;
      asm_q      <= '0;
      word_q     <= '0;
      pull_q     <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (start_ev) begin
        state_q    <= FR_SHIFT;
        bit_cnt_q  <= '0;
        in_hdr_q   <= 1'b1;
        byte_cnt_q <= '0;
        asm_q      <= '0;
        pull_q     <= 1'b0;
      end else if (stop_ev) begin
        state_q   <= FR_IDLE;
        bit_cnt_q <= '0;
        pull_q    <= 1'b0;
      end else begin
        unique case (state_q)
          FR_SHIFT: begin
            if (scl_rise && (bit_cnt_q < LAST_BIT)) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_done) begin
              state_q <= FR_ACK;
              if (in_hdr_q) begin
                pull_q <= header_accept(shreg_q, local_addr, BCAST_ADDR);
              end else if (byte_cnt_q < BYTE_LIM) begin
                pull_q     <= 1'b1;
                byte_cnt_q <= byte_cnt_q + 1'b1;
                asm_q      <= asm_next;
                if (byte_cnt_q == BYTE_LAST) begin
                  word_q <= asm_next;
                  vld_q  <= 1'b1;
                end
              end else begin
                pull_q <= 1'b0;
              end
            end
          end
          FR_ACK: begin
            if (scl_fall) begin
              pull_q    <= 1'b0;
              bit_cnt_q <= '0;
              in_hdr_q  <= 1'b0;
              state_q   <= pull_q ? FR_SHIFT : FR_IGNORE;
            end
          end
          default: begin
            bit_cnt_q <= '0;
          end
        endcase
      end
    end
  end

  assign pull_o = pull_q;
  assign word_o = word_q;
  assign vld_o  = vld_q;
  assign bits_o = bit_cnt_q;

endmodule

// File: rtl/i2c_word_sink.sv
module i2c_word_sink
  import i2c_ws_pkg::*;
#(
  parameter int unsigned  PAYLOAD_BYTES = 3,
  parameter int unsigned  SYNC_STAGES   = 2,
  parameter logic [6:0]   BCAST_ADDR    = 7'b1110011,
  localparam int unsigned WORD_W        = PAYLOAD_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] local_addr_i,
  output logic              sda_pull_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);

  // Index 0 is the clock line, index 1 the data line.
  logic [1:0] pin_in, pin_lvl, pin_rise, pin_fall;
  assign pin_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    ws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (pin_in[g]),
      .level_o (pin_lvl[g]),
      .rise_o  (pin_rise[g]),
      .fall_o  (pin_fall[g])
    );
  end

  // Named internal events, observed by the bound checker.
  logic       scl_lvl, scl_rise, scl_fall;
  logic       sda_lvl, sda_rise, sda_fall;
  logic       start_ev, stop_ev;
  logic [3:0] bits_seen;

  assign scl_lvl  = pin_lvl[0];
  assign scl_rise = pin_rise[0];
  assign scl_fall = pin_fall[0];
  assign sda_lvl  = pin_lvl[1];
  assign sda_rise = pin_rise[1];
  assign sda_fall = pin_fall[1];

  ws_bus_cond u_cond (
    .scl_lvl  (scl_lvl),
    .sda_rise (sda_rise),
    .sda_fall (sda_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  ws_frame_ctl #(
    .PAYLOAD_BYTES (PAYLOAD_BYTES),
    .BCAST_ADDR    (BCAST_ADDR)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_lvl    (sda_lvl),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .local_addr (local_addr_i),
    .pull_o     (sda_pull_o),
    .word_o     (word_o),
    .vld_o      (word_vld_o),
    .bits_o     (bits_seen)
  );

endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              scl_fall,
  input logic              start_ev,
  input logic              stop_ev,
  input logic [3:0]        bits_seen,
  input logic              sda_pull_o,
  input logic              word_vld_o,
  input logic [WORD_W-1:0] word_o
);

  p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (bits_seen == 4'd0) && !sda_pull_o);

  p_ack_held_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o && scl_lvl && !start_ev && !stop_ev) |=> sda_pull_o);

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

  p_strobe_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> sda_pull_o);

  p_pull_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall));

  p_release_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> $past(scl_fall || start_ev || stop_ev));

  p_pull_only_in_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (bits_seen == 4'd8));

  p_word_moves_on_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> word_vld_o);

endmodule

bind i2c_word_sink ws_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_lvl    (scl_lvl),
  .scl_fall   (scl_fall),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .bits_seen  (bits_seen),
  .sda_pull_o (sda_pull_o),
  .word_vld_o (word_vld_o),
  .word_o     (word_o)
);

// File: tb/tb_i2c_word_sink.sv
module tb_i2c_word_sink;

  localparam logic [6:0] LOCAL_A = 7'h12;
  localparam logic [6:0] BCAST_A = 7'b1110011;
  localparam int         Q       = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_drv = 1'b1;
  logic        sda_drv = 1'b1;
  logic        sda_line;
  logic        sda_pull_o;
  logic [23:0] word_o;
  logic        word_vld_o;

  int checks = 0;
  int fails  = 0;
  int vld_cnt = 0;
  int dbl_cnt = 0;
  logic [23:0] last_word = '0;
  logic prev_vld = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull_o;

  i2c_word_sink dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_drv),
    .sda_i        (sda_line),
    .local_addr_i (LOCAL_A),
    .sda_pull_o   (sda_pull_o),
    .word_o       (word_o),
    .word_vld_o   (word_vld_o)
  );

  always @(negedge clk) begin
    if (word_vld_o) begin
      vld_cnt++;
      last_word = word_o;
      if (prev_vld) dbl_cnt++;
    end
    prev_vld = word_vld_o;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b1; wq();
  endtask

  // One data bit; reports whether the target pulled during the high time.
  task automatic send_bit(input logic b, output logic pulled);
    sda_drv = b; wq();
    scl_drv = 1'b1; wq();
    pulled = sda_pull_o;
    wq();
    pulled = pulled | sda_pull_o;
    scl_drv = 1'b0; wq();
  endtask

  // Eight bits MSB first plus the ninth clock; ack needs the line low
  // at both ends of the high period.
  task automatic send_byte(input logic [7:0] v, output logic ack, output logic early);
    logic p, a0, a1;
    early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i], p);
      early = early | p;
    end
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1;
    @(negedge clk);
    a0 = ~sda_line;
    repeat (2 * Q - 2) @(negedge clk);
    a1 = ~sda_line;
    @(negedge clk);
    scl_drv = 1'b0; wq();
    ack = a0 & a1;
  endtask

  // Full write frame of three bytes followed by extra bytes and STOP.
  task automatic write_frame(input logic [6:0] a, input logic [23:0] w, input int extra,
                             input logic exp_ok);
    logic ack, early;
    int   v0;
    logic [23:0] w0;
    v0 = vld_cnt;
    w0 = word_o;
    bus_start();
    send_byte({a, 1'b0}, ack, early);
    check(ack == exp_ok, "R3 header ack", 32'(ack), 32'(exp_ok));
    for (int k = 0; k < 3; k++) begin
      send_byte(w[23 - 8*k -: 8], ack, early);
      check(ack == exp_ok, "R5 data byte ack", 32'(ack), 32'(exp_ok));
      check(!early, "R8 no pull during data bits", 32'(early), 32'd0);
    end
    if (exp_ok) begin
      check(vld_cnt == v0 + 1, "R6 one strobe per payload", 32'(vld_cnt), 32'(v0 + 1));
      check(last_word == w, "R6 strobed word", 32'(last_word), 32'(w));
      check(word_o == w, "R6 word held", 32'(word_o), 32'(w));
    end else begin
      check(vld_cnt == v0, "R3 no strobe on mismatch", 32'(vld_cnt), 32'(v0));
      check(word_o == w0, "R3 word unchanged", 32'(word_o), 32'(w0));
    end
    for (int k = 0; k < extra; k++) begin
      send_byte(8'hC3 ^ 8'(k), ack, early);
      check(ack == 1'b0, "R7 extra byte refused", 32'(ack), 32'd0);
    end
    if (exp_ok) begin
      check(vld_cnt == v0 + 1, "R7 no strobe for extra", 32'(vld_cnt), 32'(v0 + 1));
      check(word_o == w, "R7 word kept", 32'(word_o), 32'(w));
    end
    bus_stop();
    wq();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack, early, p;
    int   v0;
    logic [23:0] w0;
    repeat (5) @(negedge clk);
    // R10: reset state
    check(sda_pull_o == 1'b0, "R10 pull after reset", 32'(sda_pull_o), 32'd0);
    check(word_vld_o == 1'b0, "R10 strobe after reset", 32'(word_vld_o), 32'd0);
    check(word_o == 24'd0, "R10 word after reset", 32'(word_o), 32'd0);
    rst_n = 1'b1;
    wq();

    // R3 / R2 / R8: sweep every header address as a write
    for (int a = 0; a < 128; a++) begin
      logic exp;
      exp = (7'(a) == LOCAL_A) || (7'(a) == BCAST_A);
      bus_start();
      send_byte({7'(a), 1'b0}, ack, early);
      check(ack == exp, "R3 address sweep", 32'(a * 2 + int'(ack)), 32'(a * 2 + int'(exp)));
      check(!early, "R8 pull in header bits", 32'(early), 32'd0);
      bus_stop();
    end
    check(vld_cnt == 0, "R9 no strobe in header-only frames", 32'(vld_cnt), 32'd0);

    // R4: read request to own address
    bus_start();
    send_byte({LOCAL_A, 1'b1}, ack, early);
    check(ack == 1'b0, "R4 read header refused", 32'(ack), 32'd0);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'h5A, ack, early);
      check(ack == 1'b0, "R4 bytes after read ignored", 32'(ack), 32'd0);
    end
    bus_stop();
    check(vld_cnt == 0, "R4 no strobe after read", 32'(vld_cnt), 32'd0);

    // R5 / R6 / R7: full writes, several patterns, both addresses
    write_frame(LOCAL_A, 24'hA53C0F, 1, 1'b1);
    write_frame(BCAST_A, 24'h0180FF, 2, 1'b1);
    write_frame(LOCAL_A, 24'hFFFFFF, 0, 1'b1);
    write_frame(BCAST_A, 24'h000000, 1, 1'b1);
    write_frame(7'h13, 24'h123456, 0, 1'b0);

    // R9: STOP after two data bytes
    v0 = vld_cnt; w0 = word_o;
    bus_start();
    send_byte({LOCAL_A, 1'b0}, ack, early);
    send_byte(8'h9E, ack, early);
    send_byte(8'h77, ack, early);
    check(ack == 1'b1, "R5 second byte ack", 32'(ack), 32'd1);
    bus_stop();
    check(vld_cnt == v0, "R9 partial frame strobe", 32'(vld_cnt), 32'(v0));
    check(word_o == w0, "R9 partial frame word", 32'(word_o), 32'(w0));

    // R1: repeated START after one data byte, then a clean payload
    v0 = vld_cnt;
    bus_start();
    send_byte({LOCAL_A, 1'b0}, ack, early);
    send_byte(8'hEE, ack, early);
    bus_start();
    send_byte({LOCAL_A, 1'b0}, ack, early);
    check(ack == 1'b1, "R1 header after repeated start", 32'(ack), 32'd1);
    send_byte(8'h12, ack, early);
    send_byte(8'h34, ack, early);
    send_byte(8'h56, ack, early);
    bus_stop();
    check(vld_cnt == v0 + 1, "R1 one strobe after restart", 32'(vld_cnt), 32'(v0 + 1));
    check(word_o == 24'h123456, "R1 word after restart", 32'(word_o), 32'h123456);

    // R1: START in the middle of a header byte
    v0 = vld_cnt;
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1, p);
    bus_start();
    send_byte({BCAST_A, 1'b0}, ack, early);
    check(ack == 1'b1, "R1 header after mid-byte start", 32'(ack), 32'd1);
    send_byte(8'hDE, ack, early);
    send_byte(8'hAD, ack, early);
    send_byte(8'h01, ack, early);
    bus_stop();
    check(word_o == 24'hDEAD01, "R1 word after mid-byte start", 32'(word_o), 32'hDEAD01);
    check(vld_cnt == v0 + 1, "R1 strobe after mid-byte start", 32'(vld_cnt), 32'(v0 + 1));

    // R6 / R11: strobe never lasted two cycles
    check(dbl_cnt == 0, "R6 strobe width", 32'(dbl_cnt), 32'd0);
    check(sda_pull_o == 1'b0, "R8 pull idle at end", 32'(sda_pull_o), 32'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule